// File: doc/BRIEF.md
# Fractional-Counter Interpolation Controller

This block paces the interpolator of a symbol-timing recovery loop. It holds a fixed-point phase value in the range [0,1) and, on every input sample that is flagged as valid, lowers that value by a step equal to the nominal per-sample advance (one over the samples-per-symbol count) plus a signed correction from the timing loop filter. When the subtraction borrows, the counter has passed through zero, and it wraps modulo one. That sample is the base point of the next interpolant.

On a wrapping sample the controller raises a one-cycle strobe and publishes the fractional interval mu. Mu is the phase value just before the subtraction, divided by the step. A build-time selector picks how the division is done. The cheap variant multiplies by the samples-per-symbol count, which stands in for the reciprocal of the step. The exact variant uses a true divider. Mu is registered and stays unchanged until the next strobe. Over time the loop-filter correction moves the strobes so they line up with the optimum sampling instants.

Top module: `ictl_top`

## Requirements
- R1: Reset is synchronous and active high. It loads the phase counter with one half (0x8000 at the default 16-bit width) and clears `strobe` and `mu` to zero. Consequently, with a zero correction and 4 samples per symbol, the first strobe follows the third valid sample after reset.
- R2: The step is the nominal advance round(2^ACC_W / SPS) plus the sign-extended `loop_v`, expressed in counter LSBs. On each valid sample the counter drops by the step, modulo 2^ACC_W.
- R3: `strobe` is high for exactly the one cycle after a valid sample whose subtraction borrows, meaning the counter value was smaller than the step. It is low in every other cycle.
- R4: When `sample_en` is low, the counter holds its value and no strobe is produced.
- R5: The step is saturated to the range [1, 2^ACC_W − 1]. A large negative correction still advances the counter by one LSB per sample. A large positive correction gives a strobe on every sample except one where the counter holds the all-ones value.
- R6: With MU_DIVIDE clear, mu is taken from the counter value c just before the wrapping subtraction: p = c·SPS, forced to all ones if p ≥ 2^ACC_W, otherwise the top MU_W bits of the ACC_W-bit value p.
- R7: With MU_DIVIDE set, mu = floor(c·2^MU_W / step), where c is the counter value just before the wrapping subtraction.
- R8: `mu` changes only in the cycle in which `strobe` is high and is held in all other cycles.
- R9: With a zero correction, strobes occur exactly once every SPS valid samples. Idle cycles between samples do not disturb this spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Marks a cycle that carries a valid input sample |
| loop_v | input | V_W | Signed loop-filter correction, in counter LSBs |
| strobe | output | 1 | Base-point marker, one cycle, one cycle after the wrapping sample |
| mu | output | MU_W | Fractional interval, unsigned fraction, held between strobes |

## Verification
Every result of this block is due exactly one clock edge after the sample that causes it. The inputs for a sample are applied on a falling edge. `strobe` and `mu` are then read two nanoseconds after the next rising edge, so each read observes the registers updated by that sample and no later one. A model in the bench follows the counter from the requirement arithmetic. Both mu variants are instantiated side by side and compared against that model on every sample, including idle cycles, so any change to mu while no strobe is present is caught.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    typedef enum logic {
        MU_BY_SPS = 1'b0,
        MU_BY_DIV = 1'b1
    } mu_mode_e;

    // nominal per-sample advance in counter LSBs, rounded
    function automatic longint nominal_step(input int acc_w, input int sps);
        longint full;
        full = longint'(1) << acc_w;
        return (full + longint'(sps / 2)) / longint'(sps);
    endfunction

    // width needed to hold value x
    function automatic int bits_for(input longint x);
        int b;
        b = 1;
        while ((longint'(1) << b) <= x) b++;
        return b;
    endfunction

endpackage

// File: rtl/ictl_step.sv
module ictl_step
    import ictl_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int V_W   = 17,
    parameter int SPS   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [V_W-1:0]   loop_v,
    output logic [ACC_W-1:0]        step_w
);
    localparam int     SUM_W = ACC_W + 3;
    localparam longint NOM   = nominal_step(ACC_W, SPS);
    localparam longint TOP   = (longint'(1) << ACC_W) - 1;

    logic signed [SUM_W-1:0] nom_s;
    logic signed [SUM_W-1:0] v_s;
    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        nom_s = SUM_W'(NOM);
        v_s   = SUM_W'(loop_v);
        sum_s = nom_s + v_s;
        if (sum_s < SUM_W'(1))
            step_w = ACC_W'(1);
        else if (sum_s > SUM_W'(TOP))
            step_w = ACC_W'(TOP);
        else
            step_w = sum_s[ACC_W-1:0];
    end

    // R5
    step_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        step_w != '0);

endmodule

// File: rtl/ictl_phase.sv
module ictl_phase #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [ACC_W-1:0] step_w,
    output logic [ACC_W-1:0] eta_q,
    output logic             wrap
);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

    logic [ACC_W:0] diff;

    always_comb begin
        diff = {1'b0, eta_q} - {1'b0, step_w};
        wrap = diff[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            eta_q <= HALF;
        else if (sample_en)
            eta_q <= diff[ACC_W-1:0];
    end

    // R4
    eta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(eta_q));

    // R2
    eta_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !wrap) |=> (eta_q == $past(eta_q) - $past(step_w)));

endmodule

// File: rtl/ictl_mu.sv
module ictl_mu
    import ictl_pkg::*;
#(
    parameter int       ACC_W = 16,
    parameter int       MU_W  = 12,
    parameter int       SPS   = 4,
    parameter mu_mode_e MODE  = MU_BY_SPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [ACC_W-1:0] eta_q,
    input  logic [ACC_W-1:0] step_w,
    output logic             strobe,
    output logic [MU_W-1:0]  mu
);
    localparam int SPS_W  = bits_for(longint'(SPS));
    localparam int PROD_W = ACC_W + SPS_W;
    localparam int NUM_W  = ACC_W + MU_W;

    logic [MU_W-1:0] mu_next;

    generate
        if (MODE == MU_BY_SPS) begin : g_recip
            logic [PROD_W-1:0] prod;
            always_comb begin
                prod = PROD_W'(eta_q) * PROD_W'(SPS);
                if (prod[PROD_W-1:ACC_W] != '0)
                    mu_next = '1;
                else
                    mu_next = prod[ACC_W-1 -: MU_W];
            end
        end else begin : g_div
            logic [NUM_W-1:0] num;
            logic [NUM_W-1:0] quo;
            always_comb begin
                num     = {eta_q, {MU_W{1'b0}}};
                quo     = num / NUM_W'(step_w);
                mu_next = quo[MU_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
            mu     <= '0;
        end else begin
            strobe <= fire;
            if (fire)
                mu <= mu_next;
        end
    end

    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(fire));

    // R8
    mu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> $stable(mu));

endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int V_W       = 17,
    parameter int SPS       = 4,
    parameter int MU_W      = 12,
    parameter bit MU_DIVIDE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_en,
    input  logic signed [V_W-1:0] loop_v,
    output logic                  strobe,
    output logic [MU_W-1:0]       mu
);
    localparam mu_mode_e MODE = MU_DIVIDE ? MU_BY_DIV : MU_BY_SPS;

    logic [ACC_W-1:0] step_w;
    logic [ACC_W-1:0] eta_q;
    logic             wrap;
    logic             fire;

    ictl_step #(.ACC_W(ACC_W), .V_W(V_W), .SPS(SPS)) u_step (
        .clk(clk), .rst(rst), .loop_v(loop_v), .step_w(step_w)
    );

    ictl_phase #(.ACC_W(ACC_W)) u_phase (
        .clk(clk), .rst(rst), .sample_en(sample_en), .step_w(step_w),
        .eta_q(eta_q), .wrap(wrap)
    );

    assign fire = sample_en & wrap;

    ictl_mu #(.ACC_W(ACC_W), .MU_W(MU_W), .SPS(SPS), .MODE(MODE)) u_mu (
        .clk(clk), .rst(rst), .fire(fire), .eta_q(eta_q), .step_w(step_w),
        .strobe(strobe), .mu(mu)
    );

endmodule

// File: tb/sim_ictl_top.sv
module sim_ictl_top;
    localparam int ACC = 16;
    localparam int VW  = 17;
    localparam int N   = 4;
    localparam int MW  = 12;
    localparam int NOM = 16384;
    localparam int NV  = 24;
    // stimulus table: {enable, correction}
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 17'sd0},     {1'b1, 17'sd300},   {1'b1, 17'sd300},   {1'b1, -17'sd500},
        {1'b0, 17'sd0},     {1'b1, 17'sd1200},  {1'b1, 17'sd1200},  {1'b1, 17'sd1200},
        {1'b1, -17'sd2000}, {1'b1, 17'sd77},    {1'b0, 17'sd999},   {1'b1, 17'sd4096},
        {1'b1, 17'sd8000},  {1'b1, -17'sd8000}, {1'b1, 17'sd15},    {1'b1, 17'sd0},
        {1'b1, 17'sd3000},  {1'b1, 17'sd3000},  {1'b0, -17'sd4000}, {1'b1, -17'sd4000},
        {1'b1, 17'sd20000}, {1'b1, 17'sd123},   {1'b1, -17'sd321},  {1'b1, 17'sd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [VW-1:0] v = '0;
    logic st0, st1;
    logic [MW-1:0] mu0, mu1;

    int tests = 0;
    int fails = 0;
    int m_eta;
    int m_mr, m_md;
    bit done = 0;

    always #4 clk = ~clk;

    ictl_top #(.ACC_W(ACC), .V_W(VW), .SPS(N), .MU_W(MW), .MU_DIVIDE(1'b0)) u0 (
        .clk(clk), .rst(rst), .sample_en(en), .loop_v(v), .strobe(st0), .mu(mu0));
    ictl_top #(.ACC_W(ACC), .V_W(VW), .SPS(N), .MU_W(MW), .MU_DIVIDE(1'b1)) u1 (
        .clk(clk), .rst(rst), .sample_en(en), .loop_v(v), .strobe(st1), .mu(mu1));

    function automatic int stepw(input int cv);
        int s;
        s = NOM + cv;
        if (s < 1) s = 1;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive, let one rising edge pass, then compare
    task automatic sample(input string req, input logic e, input int cv, output logic got_st);
        int w;
        int exp_st;
        @(negedge clk);
        en = e;
        v  = VW'(cv);
        exp_st = 0;
        if (e) begin
            w = stepw(cv);
            if (m_eta < w) begin
                exp_st = 1;
                m_mr = (m_eta * N >= 65536) ? 4095 : ((m_eta * N) >> 4);
                m_md = int'((longint'(m_eta) << MW) / longint'(w));
            end
            m_eta = (m_eta - w + 65536) % 65536;
        end
        @(posedge clk);
        #2;
        check({req, " strobe"}, int'(st0), exp_st);
        check({req, " strobe div"}, int'(st1), exp_st);
        check("R6 mu", int'(mu0), m_mr);
        check("R7 mu", int'(mu1), m_md);
        got_st = st0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_eta = 32768;
        m_mr  = 0;
        m_md  = 0;
    endtask

    initial begin : main
        logic s;
        int cnt;
        do_reset();
        #1;
        check("R1 strobe reset", int'(st0), 0);
        check("R1 mu reset", int'(mu0), 0);
        check("R1 mu reset div", int'(mu1), 0);

        // R1 / R9: first strobe on third sample, then every N samples
        for (int i = 1; i <= 15; i++) begin
            sample("R9", 1'b1, 0, s);
            check("R1 R9 strobe position", int'(s), ((i + 1) % N == 0) ? 1 : 0);
        end

        // R4: idle cycles change nothing, spacing continues (R9)
        for (int i = 0; i < 6; i++) sample("R4", 1'b0, 0, s);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            sample("R9", 1'b1, 0, s);
            cnt += int'(s);
        end
        check("R9 strobes per 8 samples", cnt, 2);

        // R2 R3 R6 R7 R8: table of varied corrections
        for (int i = 0; i < NV; i++)
            sample("R3", VEC[i][17], int'($signed(VEC[i][16:0])), s);

        // R5: large negative correction, one-LSB steps, no strobe
        do_reset();
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            sample("R5", 1'b1, -65536, s);
            cnt += int'(s);
        end
        check("R5 no strobe at min step", cnt, 0);

        // R5: large positive correction, strobe almost every sample
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            sample("R5", 1'b1, 65535, s);
            cnt += int'(s);
        end
        check("R5 strobes at max step", cnt, 8);

        // R2: mixed run to exercise mu values with nonzero counter
        for (int i = 0; i < 12; i++) sample("R2", 1'b1, (i * 1731) % 9000 - 4000, s);

        // R1: reset mid-run restores outputs
        do_reset();
        #1;
        check("R1 strobe after rerun reset", int'(st0), 0);
        check("R1 mu after rerun reset", int'(mu0), 0);
        for (int i = 1; i <= 4; i++) begin
            sample("R1", 1'b1, 0, s);
            check("R1 strobe position after reset", int'(s), (i == 3) ? 1 : 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule